// File: doc/BRIEF.md
# Retired-Instruction Counter with Read Forwarding

This block keeps the 64-bit count of retired instructions for a core that can commit up to two instructions per cycle. Slot 0 of the retire strobe is always the oldest instruction of the cycle. A CSR read of the counter is tagged with the slot it commits in. The value it returns covers every older instruction: those retired in earlier cycles and those in lower slots of the same cycle. It never covers the reading instruction itself.

Retirements are accumulated through a one-cycle pending stage before they reach the count register. A read therefore cannot simply return the register. The read path adds the pending increment and the same-cycle older retirements combinationally, so the instruction just before a read is always seen. A read that does this wrongly shows a one-instruction lag.

A CSR write replaces the count in the cycle it commits. It takes priority over that cycle's increment: the writer and anything older in the same cycle are dropped. Younger retirements in that cycle, and all later ones, are counted on top of the written value.

Top module: `instret_counter`

## Requirements
- R1: After a synchronous active-low reset, the count is zero, so the first read returns 0 when it is the only instruction retiring in its cycle.
- R2: Every retiring instruction adds exactly one to the count, whatever its kind. The retire strobe is packed from slot 0: a higher slot is only valid when every lower slot is valid.
- R3: A read returns a value that excludes its own retirement. The reading instruction is itself retiring in the slot given by `rd_slot`.
- R4: A read includes the retirements of all earlier cycles, including the cycle directly before it, which is still pending inside the block.
- R5: A read in slot 1 includes the retirement in slot 0 of the same cycle.
- R6: Two reads committing in consecutive cycles, each alone in its cycle, return values that differ by exactly one.
- R7: The read result appears on `rd_data` with `rd_valid` high exactly one cycle after `rd_req`. `rd_valid` is low in every other cycle.
- R8: A write sets the count to `wr_data`. In that cycle, the writer and any older retirement are not counted, while younger retirements in the same cycle are counted. The writer retires in slot `wr_slot`.
- R9: A read in a higher slot than a write in the same cycle returns the written value plus the retirements between the two slots. A read in the same or a lower slot returns the old count.
- R10: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 2 | Retire strobe per slot; bit 0 is the oldest |
| rd_req | input | 1 | A counter read commits this cycle |
| rd_slot | input | 1 | Slot of the reading instruction |
| wr_en | input | 1 | A counter write commits this cycle |
| wr_slot | input | 1 | Slot of the writing instruction |
| wr_data | input | 64 | Value written to the count |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | 64 | Read result, registered |

## Verification
Single reads, each alone in its cycle, are issued back to back after a warm-up read. These separate a correct read from one that lags one instruction behind. An idle retirement directly before a read shows whether the pending stage is forwarded. A dual retirement with the read in slot 1 shows whether the same-cycle older retirement is included. Writes placed in slot 0 and slot 1, some with a read in the same or the next cycle, distinguish write priority from increment priority and show which same-cycle neighbours count. A write just below 2^64 checks the wrap. Long random mixes of zero, one and two retirements, with reads and writes in random slots, are compared against a program-order count.

// File: rtl/instret_pkg.sv
// Package: shared defaults and the forward-source encoding for the
// retired-instruction counter. Assumes nothing beyond IEEE 1800-2017.
package instret_pkg;
    localparam int DEF_CNT_W     = 64;
    localparam int DEF_NUM_SLOTS = 2;

    // Which base the read path builds its result on.
    typedef enum logic {
        FWD_COUNT = 1'b0,   // register plus pending plus older slots
        FWD_WRITE = 1'b1    // same-cycle write plus slots between
    } fwd_src_e;
endpackage

// File: rtl/instret_slot_count.sv
// Module: instret_slot_count
// Builds prefix counts over the retire strobe: older[k] is the number of
// valid slots below slot k, and older[NUM_SLOTS] is the cycle total.
// Assumes the strobe is packed from slot 0 (checked at the top).
module instret_slot_count #(
    parameter int NUM_SLOTS = 2,
    localparam int PEND_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_SLOTS-1:0]             ret_valid,
    output logic [NUM_SLOTS:0][PEND_W-1:0]   older
);
    assign older[0] = '0;

    // One adder per slot, chained from the oldest slot upward.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_prefix
        assign older[k+1] = older[k] + PEND_W'(ret_valid[k]);
    end
endmodule

// File: rtl/instret_accum.sv
// Module: instret_accum
// Holds the count register and a one-cycle pending increment. Each cycle
// the pending amount is folded into the count and the current cycle's
// retirements become pending. A write replaces the count, drops the older
// pending amount, and keeps only the retirements younger than the writer.
// Assumes thru_wr counts slots up to and including the writer.
module instret_accum #(
    parameter int CNT_W     = 64,
    parameter int NUM_SLOTS = 2,
    localparam int PEND_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [PEND_W-1:0] total,
    input  logic [PEND_W-1:0] thru_wr,
    output logic [CNT_W-1:0]  base,
    output logic [PEND_W-1:0] pending
);
    // Count register: a write wins over the increment of its cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     base <= '0;
        else if (wr_en) base <= wr_data;
        else            base <= base + CNT_W'(pending);
    end

    // Pending stage: this cycle's retirements, minus those at or below a writer.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= '0;
        else if (wr_en) pending <= total - thru_wr;
        else            pending <= total;
    end

    // Pending never exceeds the slot count (R2).
    assert_pending_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(NUM_SLOTS));
endmodule

// File: rtl/instret_read_fwd.sv
// Module: instret_read_fwd
// Forms the value a read sees: either the count register plus the pending
// increment plus older same-cycle slots, or a same-cycle older write plus
// the slots between writer and reader. The result is registered.
// Assumes the caller flags wr_before only when the writer is in a lower slot.
module instret_read_fwd
    import instret_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int NUM_SLOTS = 2,
    localparam int PEND_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_before,
    input  logic [CNT_W-1:0]  base,
    input  logic [PEND_W-1:0] pending,
    input  logic [PEND_W-1:0] older_rd,
    input  logic [PEND_W-1:0] thru_wr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);
    fwd_src_e         src;
    logic [CNT_W-1:0] fwd_value;

    // Choose the base of the forwarded value.
    always_comb src = wr_before ? FWD_WRITE : FWD_COUNT;

    // Forwarding adder: add everything older than the reader.
    always_comb begin
        case (src)
            FWD_WRITE: fwd_value = wr_data + CNT_W'(older_rd - thru_wr);
            default:   fwd_value = base + CNT_W'(pending) + CNT_W'(older_rd);
        endcase
    end

    // Result register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= fwd_value;
        end
    end

    // Valid follows the request by one cycle (R7).
    assert_valid_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/instret_counter.sv
// Module: instret_counter (top)
// Retired-instruction counter with read forwarding for a core that commits
// up to NUM_SLOTS instructions per cycle, slot 0 being the oldest. Reads
// see all older retirements and not their own; writes take priority over
// the increment of their cycle. Assumes a reader or writer is itself
// retiring in its tagged slot and that the strobe is packed from slot 0.
module instret_counter
    import instret_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int PEND_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] ret_valid,
    input  logic                 rd_req,
    input  logic [SLOT_W-1:0]    rd_slot,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [CNT_W-1:0]     wr_data,
    output logic                 rd_valid,
    output logic [CNT_W-1:0]     rd_data
);
    logic [NUM_SLOTS:0][PEND_W-1:0] older;
    logic [PEND_W-1:0]              older_rd;
    logic [PEND_W-1:0]              thru_wr;
    logic [PEND_W-1:0]              total;
    logic [CNT_W-1:0]               base;
    logic [PEND_W-1:0]              pending;
    logic                           wr_before;

    instret_slot_count #(.NUM_SLOTS(NUM_SLOTS)) i_slot_count (
        .ret_valid (ret_valid),
        .older     (older)
    );

    // Select the prefix counts for the reader, the writer and the cycle total.
    always_comb begin
        older_rd  = older[PEND_W'(rd_slot)];
        thru_wr   = older[PEND_W'(wr_slot) + PEND_W'(1)];
        total     = older[NUM_SLOTS];
        wr_before = wr_en && (wr_slot < rd_slot);
    end

    instret_accum #(.CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .total   (total),
        .thru_wr (thru_wr),
        .base    (base),
        .pending (pending)
    );

    instret_read_fwd #(.CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)) i_read_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_before (wr_before),
        .base      (base),
        .pending   (pending),
        .older_rd  (older_rd),
        .thru_wr   (thru_wr),
        .wr_data   (wr_data),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Retire strobe is packed from slot 0 (R2).
    assert_retire_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({1'b0, ret_valid} + {{NUM_SLOTS{1'b0}}, 1'b1}));

    // The reading instruction retires in its own slot (R3).
    assert_reader_retires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ret_valid[rd_slot]);

    // The writing instruction retires in its own slot (R8).
    assert_writer_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ret_valid[wr_slot]);

    // Lone reads in consecutive cycles differ by one (R6).
    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_slot == '0 && ret_valid == NUM_SLOTS'(1) && !wr_en)
        ##1 (rd_req && rd_slot == '0 && !wr_en)
        |=> rd_data == $past(rd_data) + CNT_W'(1));

    // A write in the youngest slot is what a read in the next cycle returns (R8).
    assert_write_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == SLOT_W'(NUM_SLOTS - 1))
        ##1 (rd_req && rd_slot == '0 && !wr_en)
        |=> rd_data == $past(wr_data, 2));
endmodule

// File: tb/test_instret_counter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each read's expected value from a
// program-order count and queues it; the monitor pops and compares.
module test_instret_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ret_valid = '0;
    logic        rd_req = 1'b0;
    logic [0:0]  rd_slot = '0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_slot = '0;
    logic [63:0] wr_data = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit live = 1'b0;
    bit done = 1'b0;
    logic [63:0] model = '0;

    typedef struct {
        logic [63:0] data;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    instret_counter i_instret_counter (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid),
        .rd_req(rd_req), .rd_slot(rd_slot), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Drive one cycle and update the program-order model.
    task automatic step(input int nret, input bit rd, input int rs,
                        input bit wr, input int ws, input logic [63:0] wd,
                        input string tag);
        logic [63:0] v;
        logic [63:0] ev;
        exp_t e;
        @(posedge clk);
        #1;
        ret_valid = (nret == 0) ? 2'b00 : (nret == 1) ? 2'b01 : 2'b11;
        rd_req  = rd;
        rd_slot = 1'(rs);
        wr_en   = wr;
        wr_slot = 1'(ws);
        wr_data = wd;
        v  = model;
        ev = '0;
        for (int s = 0; s < 2; s++) begin
            if (s < nret) begin
                if (rd && s == rs) ev = v;
                if (wr && s == ws) v = wd;
                else               v = v + 64'd1;
            end
        end
        model = v;
        if (rd) begin
            e.data = ev; e.due = cyc + 1; e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, "R7");
    endtask

    // Monitor: compare results at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (live) begin
                if (q.size() > 0 && q[0].due == cyc) begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (!rd_valid || rd_data !== e.data) begin
                        errors++;
                        $display("FAIL %s read: actual valid=%0b data=%0d expected valid=1 data=%0d",
                                 e.tag, rd_valid, rd_data, e.data);
                    end
                end else begin
                    checks++;
                    if (rd_valid !== 1'b0) begin
                        errors++;
                        $display("FAIL R7 idle valid: actual=%0b expected=0", rd_valid);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid: actual=%0b expected=0", rd_valid);
        end
        rst_n = 1'b1;
        live  = 1'b1;

        // R1: first read after reset sees zero.
        step(1, 1, 0, 0, 0, '0, "R1");
        // R6 / R3: warm-up read then two visible reads (1, 2).
        step(1, 1, 0, 0, 0, '0, "R6");
        step(1, 1, 0, 0, 0, '0, "R6");
        step(1, 1, 0, 0, 0, '0, "R3");
        // R4: a plain retirement directly before a read.
        step(1, 0, 0, 0, 0, '0, "R4");
        step(1, 1, 0, 0, 0, '0, "R4");
        idle(2);
        step(1, 0, 0, 0, 0, '0, "R4");
        step(1, 0, 0, 0, 0, '0, "R4");
        step(1, 1, 0, 0, 0, '0, "R4");
        // R2: dual retirements with no reads, then a read.
        step(2, 0, 0, 0, 0, '0, "R2");
        step(2, 0, 0, 0, 0, '0, "R2");
        step(1, 1, 0, 0, 0, '0, "R2");
        // R5: read in slot 1 behind a same-cycle retirement.
        step(2, 1, 1, 0, 0, '0, "R5");
        step(2, 1, 1, 0, 0, '0, "R5");
        step(2, 1, 0, 0, 0, '0, "R3");
        // R8: write in youngest slot, read next cycle.
        step(2, 0, 0, 1, 1, 64'd1000, "R8");
        step(1, 1, 0, 0, 0, '0, "R8");
        // R8: write in slot 0 with a younger retirement counted.
        step(2, 0, 0, 1, 0, 64'd500, "R8");
        step(1, 1, 0, 0, 0, '0, "R8");
        // R9: write slot 0 and read slot 1 together; and read at writer slot.
        step(2, 1, 1, 1, 0, 64'd77, "R9");
        step(1, 1, 0, 1, 0, 64'd9, "R9");
        step(1, 1, 0, 0, 0, '0, "R9");
        // R10: wrap past 2^64.
        step(1, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R10");
        step(2, 0, 0, 0, 0, '0, "R10");
        step(2, 1, 1, 0, 0, '0, "R10");
        step(1, 1, 0, 0, 0, '0, "R10");

        // Random mix of single and dual retirements, reads and writes.
        for (int i = 0; i < 2000; i++) begin
            int  n;
            bit  rd;
            bit  wr;
            int  rs;
            int  ws;
            n  = $urandom_range(0, 2);
            rd = (n > 0) && ($urandom_range(0, 2) != 0);
            wr = (n > 0) && ($urandom_range(0, 7) == 0);
            rs = (n > 0) ? $urandom_range(0, n - 1) : 0;
            ws = (n > 0) ? $urandom_range(0, n - 1) : 0;
            step(n, rd, rs, wr, ws, {$urandom, $urandom}, "R4");
        end

        idle(3);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7 drain: actual=%0d pending expected=0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule